// File: doc/BRIEF.md
# Repeater Receive Statistics Counters

This block keeps two repeater-wide receive statistics as 32-bit counters. One counts received octets and the other counts received packets. It watches a receive framing stream where each accepted beat carries a byte-kind tag and an end-of-packet flag. It counts octets from the data beats only. It counts one packet on every accepted beat that has the end flag set.

A management host reaches the counters through a small register port with 8-bit data. Address 0 is the bank register. The host writes the statistics bank number there, then reads a counter by reading that counter's address four times, least significant byte first. The first read takes a snapshot of all 32 bits, so the value the host assembles stays consistent while counting goes on.

Counters are normally read-only. While either of two reset-mode configuration inputs is high, the host may load a counter one byte lane at a time. The load takes effect when the fourth byte is written.

The receive side is a valid/ready stream. A beat transfers on a clock edge where both `rx_valid` and `rx_ready` are high. `rx_ready` is low while reset is held and high at all other times, so the block never applies back-pressure. A source that holds `rx_valid` low simply inserts idle cycles.

Top module: `rmon_stat_counters`

## Requirements
- R1: While reset is held, and right after it is released, both counters read as zero, the bank register reads zero, `host_rdata` is 0x00, and both byte pointers start at byte 0.
- R2: A host write to address 0 loads the bank register, and a host read of address 0 returns it. The counters are reachable only while the bank register holds 0x05.
- R3: The octet counter (address 1) adds one for each accepted beat tagged data (`rx_kind` = 2'b10). Beats tagged preamble (2'b00) or start delimiter (2'b01) are not counted.
- R4: The packet counter (address 2) adds one for each accepted beat with `rx_last` = 1, whatever that beat's kind.
- R5: Successive reads of a counter address return bytes 0, 1, 2 and 3, least significant first. After byte 3 the next read returns byte 0 again. `host_rdata` is updated on the clock edge that samples `host_rd` and holds until the next read.
- R6: A read of byte 0 captures the whole counter. Reads of bytes 1 to 3 return that captured value even when the counter has changed since.
- R7: Host writes to a counter are ignored unless `cfg_rptr_rst` or `cfg_mgmt_rst` is high. An ignored write changes neither the counter nor its write byte pointer.
- R8: Accepted counter writes fill byte lanes 0 to 3 in order. The counter takes the assembled 32-bit value only on the edge that writes byte 3.
- R9: Both counters wrap from 0xFFFFFFFF to 0x00000000.
- R10: When a byte-3 commit and a count increment fall on the same edge, the counter takes the written value and that increment is lost.
- R11: While the bank register is not 0x05, reads of counter addresses return 0x00. Writes to counter addresses then leave the counters and the byte pointers unchanged.
- R12: Every write to the bank register returns the read and write byte pointers of both counters to byte 0.
- R13: `rx_ready` is low while reset is held and high from the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive beat valid |
| rx_ready | output | 1 | Receive beat ready (high whenever out of reset) |
| rx_kind | input | 2 | Beat kind: 00 preamble, 01 start delimiter, 10 data or FCS |
| rx_last | input | 1 | Beat ends a packet |
| cfg_rptr_rst | input | 1 | Repeater reset mode, enables host counter writes |
| cfg_mgmt_rst | input | 1 | Management reset mode, enables host counter writes |
| host_addr | input | ADDR_W | Register address: 0 bank, 1 octets, 2 packets |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | BYTE_W | Host write data |
| host_rdata | output | BYTE_W | Host read data, registered |

## Verification
A table of packets is sent through the receive stream and both counters are checked after each one. The table mixes long and short preambles, a packet with no data bytes whose end flag rides on the delimiter beat, and back-to-back beats as well as beats with idle gaps. This separates counting data beats from counting all beats, and counting end flags from counting data. Packet lengths are chosen so the totals exceed 255, which makes the byte order of a read visible. Directed cases then check the snapshot by counting between byte reads, and check writes with writing disabled, with each reset-mode input alone, and with only part of the lanes written. They also cover wrap-around, a commit on the same edge as an increment, and access from a wrong bank.

// File: rtl/rmon_stat_pkg.sv
package rmon_stat_pkg;
  typedef enum logic [1:0] {
    RX_PREAMBLE = 2'b00,
    RX_SFD      = 2'b01,
    RX_DATA     = 2'b10,
    RX_RSVD     = 2'b11
  } rx_kind_e;

  localparam int NUM_STATS  = 2;
  localparam int IDX_OCTETS = 0;
  localparam int IDX_PKTS   = 1;
endpackage

// File: rtl/rmon_rx_tap.sv
module rmon_rx_tap
  import rmon_stat_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_valid,
  output logic                 rx_ready,
  input  logic [1:0]           rx_kind,
  input  logic                 rx_last,
  output logic [NUM_STATS-1:0] inc
);
  logic rdy_q;
  logic beat;

  // Ready rises on the first edge out of reset and then stays high.
  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign rx_ready = rdy_q;
  assign beat     = rx_valid && rdy_q;

  always_comb begin
    inc             = '0;
    inc[IDX_OCTETS] = beat && (rx_kind == RX_DATA);
    inc[IDX_PKTS]   = beat && rx_last;
  end
endmodule

// File: rtl/rmon_stat_slot.sv
module rmon_stat_slot #(
  parameter  int CNT_W  = 32,
  parameter  int BYTE_W = 8,
  localparam int NBYTES = CNT_W / BYTE_W,
  localparam int PTR_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              rd_sel,
  input  logic              wr_sel,
  input  logic              ptr_clr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [PTR_W-1:0]  rd_ptr_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NBYTES - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  shadow_q;
  logic [CNT_W-1:0]  commit_val;
  logic [PTR_W-1:0]  rd_ptr_q;
  logic [PTR_W-1:0]  wr_ptr_q;
  logic [BYTE_W-1:0] lane_q [NBYTES-1];
  logic              commit;

  assign commit = wr_sel && (wr_ptr_q == LAST);

  // One staging register for each lower byte lane.
  for (genvar l = 0; l < NBYTES - 1; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)                                    lane_q[l] <= '0;
      else if (wr_sel && (wr_ptr_q == PTR_W'(l)))    lane_q[l] <= wdata;
    end
  end

  always_comb begin
    commit_val = '0;
    for (int l = 0; l < NBYTES - 1; l++)
      commit_val[l*BYTE_W +: BYTE_W] = lane_q[l];
    commit_val[CNT_W-1 -: BYTE_W] = wdata;
  end

  // A host commit wins over a count on the same edge.
  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (commit) cnt_q <= commit_val;
    else if (inc)    cnt_q <= cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         shadow_q <= '0;
    else if (rd_sel && rd_ptr_q == '0)  shadow_q <= cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ptr_clr) rd_ptr_q <= '0;
    else if (rd_sel)       rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ptr_clr) wr_ptr_q <= '0;
    else if (wr_sel)       wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + PTR_W'(1);
  end

  // Byte 0 comes live from the counter; bytes 1 and up come from the snapshot.
  always_comb begin
    if (rd_ptr_q == '0) rd_byte = cnt_q[BYTE_W-1:0];
    else                rd_byte = shadow_q[int'(rd_ptr_q)*BYTE_W +: BYTE_W];
  end

  assign cnt_o    = cnt_q;
  assign rd_ptr_o = rd_ptr_q;
endmodule

// File: rtl/rmon_host_decode.sv
module rmon_host_decode
  import rmon_stat_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter int                BYTE_W    = 8,
  parameter logic [BYTE_W-1:0] STAT_BANK = BYTE_W'(5)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ADDR_W-1:0]                 host_addr,
  input  logic                              host_wr,
  input  logic                              host_rd,
  input  logic [BYTE_W-1:0]                 host_wdata,
  input  logic                              wr_allow,
  input  logic [NUM_STATS-1:0][BYTE_W-1:0]  slot_byte,
  output logic [NUM_STATS-1:0]              rd_sel,
  output logic [NUM_STATS-1:0]              wr_sel,
  output logic                              ptr_clr,
  output logic [BYTE_W-1:0]                 bank_o,
  output logic [BYTE_W-1:0]                 host_rdata
);
  localparam logic [ADDR_W-1:0] BANK_ADDR = '0;

  logic [BYTE_W-1:0] bank_q;
  logic [BYTE_W-1:0] rdata_q;
  logic [BYTE_W-1:0] rd_next;
  logic              stat_hit;
  logic              bank_wr;

  assign stat_hit = (bank_q == STAT_BANK);
  assign bank_wr  = host_wr && (host_addr == BANK_ADDR);
  assign ptr_clr  = bank_wr;

  for (genvar i = 0; i < NUM_STATS; i++) begin : g_sel
    logic hit;
    assign hit       = stat_hit && (host_addr == ADDR_W'(i + 1));
    assign rd_sel[i] = host_rd && hit;
    assign wr_sel[i] = host_wr && wr_allow && hit;
  end

  always_comb begin
    rd_next = '0;
    if (host_addr == BANK_ADDR) begin
      rd_next = bank_q;
    end else begin
      for (int i = 0; i < NUM_STATS; i++)
        if (stat_hit && host_addr == ADDR_W'(i + 1)) rd_next = slot_byte[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       bank_q <= '0;
    else if (bank_wr) bank_q <= host_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata_q <= '0;
    else if (host_rd) rdata_q <= rd_next;
  end

  assign bank_o     = bank_q;
  assign host_rdata = rdata_q;
endmodule

// File: rtl/rmon_stat_counters.sv
module rmon_stat_counters
  import rmon_stat_pkg::*;
#(
  parameter int                CNT_W     = 32,
  parameter int                BYTE_W    = 8,
  parameter int                ADDR_W    = 4,
  parameter logic [BYTE_W-1:0] STAT_BANK = BYTE_W'(5)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [1:0]        rx_kind,
  input  logic              rx_last,
  input  logic              cfg_rptr_rst,
  input  logic              cfg_mgmt_rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata
);
  localparam int NBYTES = CNT_W / BYTE_W;
  localparam int PTR_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic [NUM_STATS-1:0]             inc;
  logic [NUM_STATS-1:0]             rd_sel;
  logic [NUM_STATS-1:0]             wr_sel;
  logic [NUM_STATS-1:0][BYTE_W-1:0] slot_byte;
  logic [NUM_STATS-1:0][CNT_W-1:0]  cnt_a;
  logic [NUM_STATS-1:0][PTR_W-1:0]  rd_ptr_a;
  logic [BYTE_W-1:0]                bank_q;
  logic                             ptr_clr;
  logic                             wr_allow;

  assign wr_allow = cfg_rptr_rst || cfg_mgmt_rst;

  rmon_rx_tap u_tap (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_kind  (rx_kind),
    .rx_last  (rx_last),
    .inc      (inc)
  );

  rmon_host_decode #(
    .ADDR_W    (ADDR_W),
    .BYTE_W    (BYTE_W),
    .STAT_BANK (STAT_BANK)
  ) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .wr_allow   (wr_allow),
    .slot_byte  (slot_byte),
    .rd_sel     (rd_sel),
    .wr_sel     (wr_sel),
    .ptr_clr    (ptr_clr),
    .bank_o     (bank_q),
    .host_rdata (host_rdata)
  );

  for (genvar s = 0; s < NUM_STATS; s++) begin : g_slot
    rmon_stat_slot #(
      .CNT_W  (CNT_W),
      .BYTE_W (BYTE_W)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (inc[s]),
      .rd_sel   (rd_sel[s]),
      .wr_sel   (wr_sel[s]),
      .ptr_clr  (ptr_clr),
      .wdata    (host_wdata),
      .rd_byte  (slot_byte[s]),
      .cnt_o    (cnt_a[s]),
      .rd_ptr_o (rd_ptr_a[s])
    );
  end
endmodule

// File: rtl/rmon_stat_chk.sv
module rmon_stat_chk
  import rmon_stat_pkg::*;
#(
  parameter int                CNT_W     = 32,
  parameter int                BYTE_W    = 8,
  parameter int                ADDR_W    = 4,
  parameter int                PTR_W     = 2,
  parameter logic [BYTE_W-1:0] STAT_BANK = BYTE_W'(5)
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [ADDR_W-1:0]                host_addr,
  input logic                             host_rd,
  input logic                             host_wr,
  input logic [BYTE_W-1:0]                host_rdata,
  input logic [BYTE_W-1:0]                bank_q,
  input logic                             wr_allow,
  input logic [NUM_STATS-1:0]             inc,
  input logic [NUM_STATS-1:0][CNT_W-1:0]  cnt_a,
  input logic [NUM_STATS-1:0][PTR_W-1:0]  rd_ptr_a
);
  localparam logic [ADDR_W-1:0] OCT_ADDR = ADDR_W'(IDX_OCTETS + 1);
  localparam logic [ADDR_W-1:0] PKT_ADDR = ADDR_W'(IDX_PKTS + 1);

  // R11
  offbank_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr != '0 && bank_q != STAT_BANK) |=> (host_rdata == '0));

  // R11
  offbank_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_q != STAT_BANK && !(host_wr && host_addr == '0)) |=> $stable(rd_ptr_a));

  // R7
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_allow && !inc[IDX_OCTETS]) |=> $stable(cnt_a[IDX_OCTETS]));

  // R3
  oct_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc[IDX_OCTETS] && !(host_wr && wr_allow && bank_q == STAT_BANK && host_addr == OCT_ADDR))
    |=> (cnt_a[IDX_OCTETS] == $past(cnt_a[IDX_OCTETS]) + CNT_W'(1)));

  // R4
  pkt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc[IDX_PKTS] && !(host_wr && wr_allow && bank_q == STAT_BANK && host_addr == PKT_ADDR))
    |=> (cnt_a[IDX_PKTS] == $past(cnt_a[IDX_PKTS]) + CNT_W'(1)));

  // R5
  rd_ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && bank_q == STAT_BANK && host_addr == OCT_ADDR)
    |=> (rd_ptr_a[IDX_OCTETS] == $past(rd_ptr_a[IDX_OCTETS]) + PTR_W'(1)));
endmodule

bind rmon_stat_counters rmon_stat_chk #(
  .CNT_W     (CNT_W),
  .BYTE_W    (BYTE_W),
  .ADDR_W    (ADDR_W),
  .PTR_W     (PTR_W),
  .STAT_BANK (STAT_BANK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_addr  (host_addr),
  .host_rd    (host_rd),
  .host_wr    (host_wr),
  .host_rdata (host_rdata),
  .bank_q     (bank_q),
  .wr_allow   (wr_allow),
  .inc        (inc),
  .cnt_a      (cnt_a),
  .rd_ptr_a   (rd_ptr_a)
);

// File: tb/rmon_stat_counters_tb.sv
module rmon_stat_counters_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic [1:0] rx_kind = 2'b00;
  logic       rx_last = 1'b0;
  logic       cfg_rptr_rst = 1'b0;
  logic       cfg_mgmt_rst = 1'b0;
  logic [3:0] host_addr = '0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #5 clk = ~clk;

  rmon_stat_counters dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rx_ready     (rx_ready),
    .rx_kind      (rx_kind),
    .rx_last      (rx_last),
    .cfg_rptr_rst (cfg_rptr_rst),
    .cfg_mgmt_rst (cfg_mgmt_rst),
    .host_addr    (host_addr),
    .host_wr      (host_wr),
    .host_rd      (host_rd),
    .host_wdata   (host_wdata),
    .host_rdata   (host_rdata)
  );

  typedef struct packed {
    logic [7:0]  n_pre;
    logic [15:0] n_data;
    logic        gap;
    logic [31:0] exp_oct;
    logic [31:0] exp_pkt;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{n_pre: 8'd7, n_data: 16'd64,  gap: 1'b0, exp_oct: 32'd64,  exp_pkt: 32'd1},
    '{n_pre: 8'd7, n_data: 16'd1,   gap: 1'b1, exp_oct: 32'd65,  exp_pkt: 32'd2},
    '{n_pre: 8'd0, n_data: 16'd100, gap: 1'b1, exp_oct: 32'd165, exp_pkt: 32'd3},
    '{n_pre: 8'd3, n_data: 16'd0,   gap: 1'b0, exp_oct: 32'd165, exp_pkt: 32'd4},
    '{n_pre: 8'd7, n_data: 16'd300, gap: 1'b0, exp_oct: 32'd465, exp_pkt: 32'd5}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic write32(input logic [3:0] a, input logic [31:0] v);
    for (int b = 0; b < 4; b++) host_write(a, v[b*8 +: 8]);
  endtask

  task automatic read32(input logic [3:0] a, output logic [31:0] v);
    logic [7:0] d;
    for (int b = 0; b < 4; b++) begin
      host_read(a, d);
      v[b*8 +: 8] = d;
    end
  endtask

  task automatic beat(input logic [1:0] k, input logic last, input logic gap);
    @(negedge clk);
    rx_valid = 1'b1; rx_kind = k; rx_last = last;
    if (gap) begin
      @(negedge clk);
      rx_valid = 1'b0;
    end
  endtask

  task automatic send_pkt(input int n_pre, input int n_data, input logic gap, input logic last);
    for (int i = 0; i < n_pre; i++) beat(2'b00, 1'b0, gap);
    beat(2'b01, last && (n_data == 0), gap);
    for (int i = 0; i < n_data; i++) beat(2'b10, last && (i == n_data - 1), gap);
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic data_only(input int n);
    for (int i = 0; i < n; i++) beat(2'b10, 1'b0, 1'b0);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [31:0] v;

    repeat (3) @(negedge clk);
    check("R13 ready low in reset", {31'd0, rx_ready}, 32'd0);
    check("R1 rdata in reset", {24'd0, host_rdata}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R13 ready high after reset", {31'd0, rx_ready}, 32'd1);

    host_read(4'd0, b);
    check("R1 bank reg reset", {24'd0, b}, 32'd0);
    host_read(4'd1, b);
    check("R11 off-bank read zero", {24'd0, b}, 32'd0);

    host_write(4'd0, 8'h05);
    host_read(4'd0, b);
    check("R2 bank readback", {24'd0, b}, 32'h05);
    read32(4'd1, v); check("R1 octets reset", v, 32'd0);
    read32(4'd2, v); check("R1 packets reset", v, 32'd0);

    // Table-driven receive patterns.
    for (int k = 0; k < NVEC; k++) begin
      send_pkt(int'(VECS[k].n_pre), int'(VECS[k].n_data), VECS[k].gap, 1'b1);
      read32(4'd1, v); check($sformatf("R3 R5 octets vec %0d", k), v, VECS[k].exp_oct);
      read32(4'd2, v); check($sformatf("R4 R5 packets vec %0d", k), v, VECS[k].exp_pkt);
    end

    // R6 snapshot while counting continues (465 -> 765).
    host_read(4'd1, b); check("R6 byte0", {24'd0, b}, 32'hD1);
    data_only(300);
    host_read(4'd1, b); check("R6 byte1 from snapshot", {24'd0, b}, 32'h01);
    host_read(4'd1, b); check("R6 byte2 from snapshot", {24'd0, b}, 32'h00);
    host_read(4'd1, b); check("R6 byte3 from snapshot", {24'd0, b}, 32'h00);
    read32(4'd1, v); check("R3 octets after data run", v, 32'd765);

    // R12 bank write realigns pointer.
    host_read(4'd1, b); check("R12 first byte0", {24'd0, b}, 32'hFD);
    host_write(4'd0, 8'h05);
    host_read(4'd1, b); check("R12 byte0 after bank write", {24'd0, b}, 32'hFD);
    for (int i = 0; i < 3; i++) host_read(4'd1, b);

    // R7 writes ignored without reset mode.
    write32(4'd1, 32'h44332211);
    read32(4'd1, v); check("R7 gated write ignored", v, 32'd765);

    // R8 lane writes commit on byte 3.
    cfg_mgmt_rst = 1'b1;
    host_write(4'd2, 8'hAA); host_write(4'd2, 8'hBB); host_write(4'd2, 8'hCC);
    read32(4'd2, v); check("R8 no commit before byte3", v, 32'd5);
    host_write(4'd2, 8'hDD);
    read32(4'd2, v); check("R8 committed value", v, 32'hDDCCBBAA);
    cfg_mgmt_rst = 1'b0; cfg_rptr_rst = 1'b1;
    write32(4'd1, 32'h12345678);
    read32(4'd1, v); check("R7 R8 write via repeater reset", v, 32'h12345678);

    // R9 wrap.
    write32(4'd1, 32'hFFFFFFFF);
    data_only(1);
    read32(4'd1, v); check("R9 octet wrap", v, 32'd0);
    write32(4'd2, 32'hFFFFFFFF);
    beat(2'b00, 1'b0, 1'b0);
    beat(2'b01, 1'b1, 1'b0);
    @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
    read32(4'd2, v); check("R9 packet wrap", v, 32'd0);
    read32(4'd1, v); check("R3 preamble and delimiter not counted", v, 32'd0);

    // R10 commit beats a same-edge increment.
    host_write(4'd1, 8'h01); host_write(4'd1, 8'h00); host_write(4'd1, 8'h00);
    @(negedge clk);
    host_wr = 1'b1; host_addr = 4'd1; host_wdata = 8'h00;
    rx_valid = 1'b1; rx_kind = 2'b10; rx_last = 1'b0;
    @(negedge clk);
    host_wr = 1'b0; rx_valid = 1'b0;
    read32(4'd1, v); check("R10 write over increment", v, 32'd1);

    // R11 wrong bank: reads zero, writes ignored.
    host_write(4'd0, 8'h06);
    host_read(4'd0, b); check("R2 other bank readback", {24'd0, b}, 32'h06);
    host_read(4'd1, b); check("R11 off-bank counter read", {24'd0, b}, 32'd0);
    write32(4'd1, 32'hEEEEEEEE);
    host_write(4'd0, 8'h05);
    read32(4'd1, v); check("R11 off-bank write ignored", v, 32'd1);
    cfg_rptr_rst = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule